// File: doc/BRIEF.md
# Delayed Read Target Controller

This block is the target side of a read on a conventional shared bus where the target cannot produce data at once. When an initiator tries to read an address and nothing is pending, the block records the address, ends the attempt with a retry, and fetches a fixed block of words from its local memory in the background. The initiator keeps repeating the same read. Every repeat is retried until the fetched words are ready. The repeat after that is accepted and served from the local buffer at one word per cycle.

The initiator never states how many words it wants. It ends the transfer by dropping its ready signal. If it keeps asking after the whole buffer has been sent, the block signals disconnect on the final word, and the initiator must start a fresh read at the following address. The block holds one pending read at a time. Buffered words that nobody collects are dropped after a programmable number of clock cycles.

Top module: `delayed_read_target`

## Requirements
- R1: An attempt (`att_valid` high for one cycle) that arrives while nothing is pending is answered with `rsp_retry` in the next cycle. The block latches `att_addr` and, from that same next cycle, raises `mem_req` to fetch `DEPTH` words at word addresses A, A+1, … A+DEPTH-1, which wrap modulo 2^ADDR_W.
- R2: Every attempt that arrives while the fetch is still in progress is answered with `rsp_retry`.
- R3: An attempt whose address differs from the latched one is answered with `rsp_retry` while a read is pending. It starts no new fetch (`mem_req` stays low once the fetch has finished) and does not alter the buffered words.
- R4: Once the fetch has finished, an attempt at the latched address is answered with `rsp_accept` in the next cycle. Word k (k = 0, 1, …) appears on `dat_word` with `dat_valid` high in the k-th cycle in which `ini_rdy` is high, counting from the cycle of `rsp_accept`.
- R5: A cycle of the transfer with `ini_rdy` low ends it and discards the buffer. The next attempt at the same address is retried and starts a new fetch.
- R6: The word with index DEPTH-1 carries `dat_last` high (disconnect). After it, `dat_valid` stays low even while `ini_rdy` is high, and the buffer is discarded.
- R7: Buffered data is discarded after `cfg_timeout` cycles without a matching attempt. Counting the first cycle after the fetch ends as cycle 0, an attempt in cycle `cfg_timeout`-1 is accepted. An attempt in cycle `cfg_timeout` is retried and starts a new fetch.
- R8: A `cfg_timeout` of zero disables the discard, so buffered data waits indefinitely.
- R9: While reset is active, and after it is released, `rsp_retry`, `rsp_accept`, `dat_valid`, `dat_last` and `mem_req` are low.
- R10: `mem_req` and `mem_addr` hold steady until `mem_ack`. Each `mem_ack` delivers exactly one word on `mem_rdata`.
- R11: The words delivered to the initiator equal the memory words at A+k, in increasing k.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_timeout | input | TMO_W | Cycles buffered data is kept without a matching attempt; 0 keeps it forever |
| att_valid | input | 1 | One-cycle pulse marking a read attempt |
| att_addr | input | ADDR_W | Word address of the attempt |
| ini_rdy | input | 1 | Initiator requests a data word this cycle |
| rsp_retry | output | 1 | Attempt ended with retry |
| rsp_accept | output | 1 | Attempt accepted, data follows |
| dat_valid | output | 1 | Data word present this cycle |
| dat_word | output | WORD_W | Data word |
| dat_last | output | 1 | Final buffered word; the target disconnects after it |
| mem_req | output | 1 | Fetch request to local memory |
| mem_addr | output | ADDR_W | Fetch word address |
| mem_ack | input | 1 | Memory returns a word this cycle |
| mem_rdata | input | WORD_W | Returned memory word |

## Verification
The hardest case to reach from the ports is the edge of the discard window. No port shows when the fetch ends, so the bench uses its own memory model. It waits for the cycle in which the model's final acknowledge takes effect and `mem_req` falls, then counts whole cycles from there. This places a matching attempt exactly one cycle before the discard, and on another pass exactly on the discard cycle. The second placement must produce a retry and a new `mem_req`. Memory latency is varied between fetches, and one fetch starts near the top of the address space so that the address wraps.

// File: rtl/drt_pkg.sv
package drt_pkg;

   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_FETCH = 2'd1,
      ST_READY = 2'd2,
      ST_XFER  = 2'd3
   } drt_state_t;

endpackage

// File: rtl/drt_fetch.sv
module drt_fetch #(
   parameter int ADDR_W = 16,
   parameter int DEPTH  = 16,
   localparam int IDX_W = $clog2(DEPTH)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [ADDR_W-1:0] base,
   output logic              mem_req,
   output logic [ADDR_W-1:0] mem_addr,
   input  logic              mem_ack,
   output logic              wr_en,
   output logic [IDX_W-1:0]  wr_idx,
   output logic              done
);
   localparam logic [IDX_W-1:0] LAST = IDX_W'(DEPTH - 1);

   logic              busy;
   logic [IDX_W-1:0]  cnt;
   logic [ADDR_W-1:0] base_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy   <= 1'b0;
         cnt    <= '0;
         base_q <= '0;
      end else if (start) begin
         busy   <= 1'b1;
         cnt    <= '0;
         base_q <= base;
      end else if (busy && mem_ack) begin
         if (cnt == LAST) begin
            busy <= 1'b0;
            cnt  <= '0;
         end else begin
            cnt <= cnt + 1'b1;
         end
      end
   end

   assign mem_req  = busy;
   assign mem_addr = base_q + ADDR_W'(cnt);
   assign wr_en    = busy && mem_ack;
   assign wr_idx   = cnt;
   assign done     = wr_en && (cnt == LAST);

   p_req_hold_r10 : assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr)));

   p_start_idle_r3 : assert property (@(posedge clk) disable iff (!rst_n)
      start |-> !busy);

endmodule

// File: rtl/drt_buffer.sv
module drt_buffer #(
   parameter int WORD_W = 32,
   parameter int DEPTH  = 16,
   localparam int IDX_W = $clog2(DEPTH)
) (
   input  logic              clk,
   input  logic              wr_en,
   input  logic [IDX_W-1:0]  wr_idx,
   input  logic [WORD_W-1:0] wr_data,
   input  logic [IDX_W-1:0]  rd_idx,
   output logic [WORD_W-1:0] rd_data
);
   logic [WORD_W-1:0] slot [DEPTH];

   for (genvar i = 0; i < DEPTH; i++) begin : g_slot
      always_ff @(posedge clk) begin
         if (wr_en && (wr_idx == IDX_W'(i)))
            slot[i] <= wr_data;
      end
   end

   assign rd_data = slot[rd_idx];

endmodule

// File: rtl/drt_timer.sv
module drt_timer #(
   parameter int TMO_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             active,
   input  logic             hit,
   input  logic [TMO_W-1:0] limit,
   output logic             expire
);
   logic [TMO_W-1:0] cnt;

   assign expire = active && !hit && (limit != '0) && (cnt == limit - TMO_W'(1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt <= '0;
      else if (!active || hit || expire)
         cnt <= '0;
      else if (limit != '0)
         cnt <= cnt + 1'b1;
   end

   p_expire_drop_r7 : assert property (@(posedge clk) disable iff (!rst_n)
      expire |=> !active);

endmodule

// File: rtl/delayed_read_target.sv
module delayed_read_target #(
   parameter int ADDR_W = 16,
   parameter int WORD_W = 32,
   parameter int DEPTH  = 16,
   parameter int TMO_W  = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [TMO_W-1:0]  cfg_timeout,
   input  logic              att_valid,
   input  logic [ADDR_W-1:0] att_addr,
   input  logic              ini_rdy,
   output logic              rsp_retry,
   output logic              rsp_accept,
   output logic              dat_valid,
   output logic [WORD_W-1:0] dat_word,
   output logic              dat_last,
   output logic              mem_req,
   output logic [ADDR_W-1:0] mem_addr,
   input  logic              mem_ack,
   input  logic [WORD_W-1:0] mem_rdata
);
   import drt_pkg::*;

   localparam int IDX_W = $clog2(DEPTH);
   localparam logic [IDX_W-1:0] LAST = IDX_W'(DEPTH - 1);

   if (DEPTH < 2)      begin : g_bad_depth $error("DEPTH must be at least 2"); end
   if (ADDR_W < IDX_W) begin : g_bad_addr  $error("ADDR_W narrower than buffer index"); end
   if (TMO_W < 1)      begin : g_bad_tmo   $error("TMO_W must be positive"); end

   drt_state_t        state;
   logic [ADDR_W-1:0] pend_addr;
   logic [IDX_W-1:0]  rd_idx;
   logic              retry_q, accept_q;

   logic              hit, fetch_start, fetch_done, expire;
   logic              wr_en;
   logic [IDX_W-1:0]  wr_idx;

   assign hit         = att_valid && (state == ST_READY) && (att_addr == pend_addr);
   assign fetch_start = att_valid && (state == ST_IDLE);

   drt_fetch #(.ADDR_W(ADDR_W), .DEPTH(DEPTH)) u_fetch (
      .clk      (clk),
      .rst_n    (rst_n),
      .start    (fetch_start),
      .base     (att_addr),
      .mem_req  (mem_req),
      .mem_addr (mem_addr),
      .mem_ack  (mem_ack),
      .wr_en    (wr_en),
      .wr_idx   (wr_idx),
      .done     (fetch_done)
   );

   drt_buffer #(.WORD_W(WORD_W), .DEPTH(DEPTH)) u_buf (
      .clk     (clk),
      .wr_en   (wr_en),
      .wr_idx  (wr_idx),
      .wr_data (mem_rdata),
      .rd_idx  (rd_idx),
      .rd_data (dat_word)
   );

   drt_timer #(.TMO_W(TMO_W)) u_tmo (
      .clk    (clk),
      .rst_n  (rst_n),
      .active (state == ST_READY),
      .hit    (hit),
      .limit  (cfg_timeout),
      .expire (expire)
   );

   assign dat_valid  = (state == ST_XFER) && ini_rdy;
   assign dat_last   = dat_valid && (rd_idx == LAST);
   assign rsp_retry  = retry_q;
   assign rsp_accept = accept_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state     <= ST_IDLE;
         pend_addr <= '0;
         rd_idx    <= '0;
         retry_q   <= 1'b0;
         accept_q  <= 1'b0;
      end else begin
         retry_q  <= att_valid && !hit;
         accept_q <= hit;
         case (state)
            ST_IDLE: begin
               if (att_valid) begin
                  pend_addr <= att_addr;
                  state     <= ST_FETCH;
               end
            end
            ST_FETCH: begin
               if (fetch_done) state <= ST_READY;
            end
            ST_READY: begin
               if (hit) begin
                  rd_idx <= '0;
                  state  <= ST_XFER;
               end else if (expire) begin
                  state <= ST_IDLE;
               end
            end
            ST_XFER: begin
               if (!ini_rdy || rd_idx == LAST) begin
                  rd_idx <= '0;
                  state  <= ST_IDLE;
               end else begin
                  rd_idx <= rd_idx + 1'b1;
               end
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

   p_one_answer_r1 : assert property (@(posedge clk) disable iff (!rst_n)
      att_valid |=> (rsp_retry != rsp_accept));

   p_fetch_on_retry_r1 : assert property (@(posedge clk) disable iff (!rst_n)
      $rose(mem_req) |-> rsp_retry);

   p_busy_retry_r2 : assert property (@(posedge clk) disable iff (!rst_n)
      (att_valid && mem_req) |=> rsp_retry);

   p_accept_quiet_r4 : assert property (@(posedge clk) disable iff (!rst_n)
      rsp_accept |-> !mem_req);

   p_disconnect_r6 : assert property (@(posedge clk) disable iff (!rst_n)
      (dat_valid && dat_last) |=> !dat_valid);

   p_resp_excl_r9 : assert property (@(posedge clk) disable iff (!rst_n)
      !(rsp_retry && rsp_accept));

endmodule

// File: tb/sim_delayed_read_target.sv
module sim_delayed_read_target;
   localparam int AW = 16, WW = 32, DP = 16, TW = 16;
   localparam int TMO = 20;

   logic          clk = 1'b0, rst_n = 1'b0;
   logic [TW-1:0] cfg_timeout = TW'(TMO);
   logic          att_valid = 1'b0, ini_rdy = 1'b0;
   logic [AW-1:0] att_addr = '0;
   logic          rsp_retry, rsp_accept, dat_valid, dat_last, mem_req;
   logic [WW-1:0] dat_word, mem_rdata = '0;
   logic [AW-1:0] mem_addr;
   logic          mem_ack = 1'b0;

   int vectors = 0, miscompares = 0, mem_lat = 2, lat_cnt = 0;
   bit done_flag = 0;
   logic [WW:0] exp_q[$];
   string       tag_q[$];

   always #5 clk = ~clk;

   delayed_read_target #(.ADDR_W(AW), .WORD_W(WW), .DEPTH(DP), .TMO_W(TW)) u0 (
      .clk(clk), .rst_n(rst_n), .cfg_timeout(cfg_timeout),
      .att_valid(att_valid), .att_addr(att_addr), .ini_rdy(ini_rdy),
      .rsp_retry(rsp_retry), .rsp_accept(rsp_accept),
      .dat_valid(dat_valid), .dat_word(dat_word), .dat_last(dat_last),
      .mem_req(mem_req), .mem_addr(mem_addr), .mem_ack(mem_ack), .mem_rdata(mem_rdata));

   function automatic logic [WW-1:0] mem_word(input logic [AW-1:0] a);
      return {a ^ 16'h5A5A, ~a};
   endfunction

   task automatic check(input bit ok, input string tag, input logic [WW:0] act, input logic [WW:0] exp);
      vectors++;
      if (!ok) begin
         miscompares++;
         $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
      end
   endtask

   // memory model: acknowledges after mem_lat waiting cycles
   always @(negedge clk) begin
      if (mem_ack) begin
         mem_ack = 1'b0;
         lat_cnt = 0;
      end else if (mem_req) begin
         if (lat_cnt >= mem_lat) begin
            mem_ack   = 1'b1;
            mem_rdata = mem_word(mem_addr);
         end else begin
            lat_cnt++;
         end
      end
   end

   // monitor: compares each delivered word with the scoreboard
   always @(negedge clk) begin
      #2;
      if (rst_n && dat_valid) begin
         if (exp_q.size() == 0) begin
            check(1'b0, "R6", {dat_last, dat_word}, '0);
         end else begin
            logic [WW:0] e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            check({dat_last, dat_word} === e, t, {dat_last, dat_word}, e);
         end
      end
   end

   // drives one attempt at negedge+1; ends at negedge+1 with the block idle or pending
   task automatic attempt(input logic [AW-1:0] a, input bit exp_acc, input int nbeats, input string tag);
      att_valid = 1'b1;
      att_addr  = a;
      ini_rdy   = exp_acc && (nbeats > 0);
      if (exp_acc) begin
         for (int k = 0; k < nbeats && k < DP; k++) begin
            exp_q.push_back({k == DP - 1, mem_word(a + AW'(k))});
            tag_q.push_back(k == DP - 1 ? "R6" : "R11");
         end
      end
      @(negedge clk); #1;
      att_valid = 1'b0;
      check(rsp_retry === !exp_acc && rsp_accept === exp_acc, tag,
            {31'd0, rsp_retry, rsp_accept}, {31'd0, !exp_acc, exp_acc});
      if (exp_acc) begin
         for (int k = 1; k <= nbeats; k++) begin
            @(negedge clk); #1;
            if (k == DP && nbeats > DP)
               check(dat_valid === 1'b0 && ini_rdy === 1'b1, "R6", {32'd0, dat_valid}, '0);
         end
         ini_rdy = 1'b0;
         @(negedge clk); #1;
      end
   endtask

   task automatic wait_fetch_done();
      while (mem_req) begin
         @(negedge clk); #1;
      end
   endtask

   task automatic check_req(input bit exp, input string tag);
      check(mem_req === exp, tag, {32'd0, mem_req}, {32'd0, exp});
   endtask

   initial begin
      #(200000 * 10);
      if (!done_flag) begin
         miscompares++;
         vectors++;
         $display("FAIL watchdog expired at %0t", $time);
         $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      #1;
      check({rsp_retry, rsp_accept, dat_valid, dat_last, mem_req} === 5'b0, "R9",
            {28'd0, rsp_retry, rsp_accept, dat_valid, dat_last, mem_req}, '0);
      rst_n = 1'b1;
      @(negedge clk); #1;
      check({rsp_retry, rsp_accept, dat_valid, mem_req} === 4'b0, "R9",
            {29'd0, rsp_retry, rsp_accept, dat_valid, mem_req}, '0);

      // first attempt, repeats during fetch, foreign address
      attempt(16'h0100, 0, 0, "R1");
      check_req(1'b1, "R1");
      attempt(16'h0100, 0, 0, "R2");
      attempt(16'h0500, 0, 0, "R3");
      attempt(16'h0100, 0, 0, "R2");
      wait_fetch_done();
      attempt(16'h0500, 0, 0, "R3");
      check_req(1'b0, "R3");
      attempt(16'h0100, 1, 5, "R4");

      // buffer discarded after a short transfer
      attempt(16'h0100, 0, 0, "R5");
      check_req(1'b1, "R5");
      mem_lat = 0;
      wait_fetch_done();
      attempt(16'h0100, 1, 20, "R4");

      // wrap of the fetch address, full transfer
      mem_lat = 5;
      attempt(16'hFFF8, 0, 0, "R1");
      wait_fetch_done();
      attempt(16'hFFF8, 1, 16, "R10");

      // discard window edges
      mem_lat = 1;
      attempt(16'h0A00, 0, 0, "R1");
      wait_fetch_done();
      repeat (TMO - 1) begin @(negedge clk); #1; end
      attempt(16'h0A00, 1, 3, "R7");
      attempt(16'h0A00, 0, 0, "R5");
      wait_fetch_done();
      repeat (TMO) begin @(negedge clk); #1; end
      attempt(16'h0A00, 0, 0, "R7");
      check_req(1'b1, "R7");
      wait_fetch_done();

      // no discard when the limit is zero
      cfg_timeout = '0;
      repeat (3 * TMO) begin @(negedge clk); #1; end
      check_req(1'b0, "R8");
      attempt(16'h0A00, 1, 16, "R8");

      repeat (4) @(negedge clk);
      check(exp_q.size() == 0, "R11", 33'(exp_q.size()), '0);
      done_flag = 1;
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
   end
endmodule